// File: doc/BRIEF.md
# CAN Message Object Control and Status Flags

This block keeps the control and status flags of a single CAN message object and presents them to the host as one 32-bit interface word. The flags are new-data, message-lost, interrupt-pending, use-mask, transmit-interrupt enable, receive-interrupt enable, remote enable, transmit request, end-of-buffer and a 4-bit data length code. The message handler changes them through two event strobes: a received frame was stored into the object, or a frame from the object was sent successfully. The host changes them by writing the interface word. The host's write is dropped while the interface transfer is busy.

The block also decides whether an incoming identifier is accepted by the object. It compares the 29-bit identifier, the extended-format bit and the direction bit. When use-mask is set, only the positions selected by the object's mask take part in the compare. When use-mask is clear, every bit must match exactly. The interrupt-pending flag is brought out so that an encoder outside the block can rank the objects.

Top module: `msgobj_status`

## Requirements
- R1: The interface word places new-data at bit 15, message-lost at 14, interrupt-pending at 13, use-mask at 12, transmit-interrupt enable at 11, receive-interrupt enable at 10, remote enable at 9, transmit request at 8, end-of-buffer at 7 and the data length code at 3:0. Bits 31:16 and 6:4 always read 0.
- R2: After an asynchronous reset every flag and the data length code read 0.
- R3: When a received frame is stored while new-data is already 1 and the object is a receive object, message-lost reads 1 from the next cycle on.
- R4: On a transmit object (`obj_dir_tx_i`=1) message-lost is never set: a host write stores 0 into it and a store event does not set it.
- R5: A transmit-complete event sets interrupt-pending when transmit-interrupt enable is 1. When the enable is 0, the event leaves interrupt-pending unchanged.
- R6: A store event sets new-data to 1. Only a host write can clear it, and a host write may also set it.
- R7: While `busy_i` is 1, host writes have no effect on any bit of the interface word.
- R8: With use-mask 1, the identifier is accepted when every identifier bit whose mask bit is 1 matches. The extended bit must also match when its mask bit is 1, and the direction bit when its mask bit is 1.
- R9: With use-mask 0, the identifier is accepted only when all 29 identifier bits, the extended bit and the direction bit match exactly.
- R10: A store event sets interrupt-pending when receive-interrupt enable is 1.
- R11: `irq_o` equals the interrupt-pending bit of the interface word.
- R12: A store event loads the data length code from `rx_dlc_i`. When a handler event and a host write reach the same flag in one cycle, the handler's value is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| host_wr_i | input | 1 | Host write strobe for the interface word |
| host_wdata_i | input | 32 | Host write data |
| busy_i | input | 1 | Interface transfer busy; blocks host writes |
| host_rdata_o | output | 32 | Interface word read back |
| obj_dir_tx_i | input | 1 | Object direction: 1 = transmit, 0 = receive |
| rx_store_i | input | 1 | Handler stored a received frame |
| rx_dlc_i | input | 4 | Length code of the stored frame |
| tx_done_i | input | 1 | Handler finished a transmission successfully |
| id_i | input | 29 | Incoming identifier |
| id_xtd_i | input | 1 | Incoming extended-format bit |
| id_dir_i | input | 1 | Incoming direction bit |
| obj_id_i | input | 29 | Object identifier |
| obj_xtd_i | input | 1 | Object extended-format bit |
| obj_dir_i | input | 1 | Object direction bit used for filtering |
| msk_id_i | input | 29 | Identifier mask; 1 = bit compared |
| msk_xtd_i | input | 1 | Mask for the extended bit |
| msk_dir_i | input | 1 | Mask for the direction bit |
| accept_o | output | 1 | Identifier accepted by this object |
| irq_o | output | 1 | Interrupt pending from this object |

## Verification
The properties assume that the handler never raises the store event and the transmit-complete event in the same cycle, because one object cannot receive and transmit at once. They also assume that the object's direction is held steady while its flags are being examined. The stimulus keeps the two event strobes mutually exclusive. It fixes the direction for a whole phase, first a receive phase and then a transmit phase. Host writes, busy periods and events are mixed freely inside each phase, and same-cycle collisions between a host write and an event occur often.

// File: rtl/msgobj_pkg.sv
package msgobj_pkg;
  localparam int unsigned DLC_W = 4;
  localparam int unsigned REG_W = 32;

  localparam int unsigned B_NEW_DAT  = 15;
  localparam int unsigned B_MSG_LOST = 14;
  localparam int unsigned B_INT_PEND = 13;
  localparam int unsigned B_USE_MASK = 12;
  localparam int unsigned B_TX_IE    = 11;
  localparam int unsigned B_RX_IE    = 10;
  localparam int unsigned B_RMT_EN   = 9;
  localparam int unsigned B_TX_REQ   = 8;
  localparam int unsigned B_END_BUF  = 7;

  typedef struct packed {
    logic             new_dat;
    logic             msg_lost;
    logic             int_pend;
    logic             use_mask;
    logic             tx_ie;
    logic             rx_ie;
    logic             rmt_en;
    logic             tx_req;
    logic             end_buf;
    logic [DLC_W-1:0] dlc;
  } obj_ctl_t;

  function automatic logic [REG_W-1:0] pack_ctl(obj_ctl_t c);
    logic [REG_W-1:0] w;
    w             = '0;
    w[B_NEW_DAT]  = c.new_dat;
    w[B_MSG_LOST] = c.msg_lost;
    w[B_INT_PEND] = c.int_pend;
    w[B_USE_MASK] = c.use_mask;
    w[B_TX_IE]    = c.tx_ie;
    w[B_RX_IE]    = c.rx_ie;
    w[B_RMT_EN]   = c.rmt_en;
    w[B_TX_REQ]   = c.tx_req;
    w[B_END_BUF]  = c.end_buf;
    w[DLC_W-1:0]  = c.dlc;
    return w;
  endfunction

  function automatic obj_ctl_t unpack_ctl(logic [REG_W-1:0] w);
    obj_ctl_t c;
    c.new_dat  = w[B_NEW_DAT];
    c.msg_lost = w[B_MSG_LOST];
    c.int_pend = w[B_INT_PEND];
    c.use_mask = w[B_USE_MASK];
    c.tx_ie    = w[B_TX_IE];
    c.rx_ie    = w[B_RX_IE];
    c.rmt_en   = w[B_RMT_EN];
    c.tx_req   = w[B_TX_REQ];
    c.end_buf  = w[B_END_BUF];
    c.dlc      = w[DLC_W-1:0];
    return c;
  endfunction
endpackage

// File: rtl/msgobj_accept.sv
module msgobj_accept #(
  parameter int unsigned ID_W = 29
) (
  input  logic            use_mask_i,
  input  logic [ID_W-1:0] id_i,
  input  logic            id_xtd_i,
  input  logic            id_dir_i,
  input  logic [ID_W-1:0] obj_id_i,
  input  logic            obj_xtd_i,
  input  logic            obj_dir_i,
  input  logic [ID_W-1:0] msk_id_i,
  input  logic            msk_xtd_i,
  input  logic            msk_dir_i,
  output logic            accept_o
);
  localparam int unsigned CMP_W = ID_W + 2;

  logic [CMP_W-1:0] cand, ref_v, msk_v, bit_ok;

  assign cand  = {id_dir_i, id_xtd_i, id_i};
  assign ref_v = {obj_dir_i, obj_xtd_i, obj_id_i};
  assign msk_v = {msk_dir_i, msk_xtd_i, msk_id_i};

  // a bit is compared when the mask is unused or its mask bit is set
  for (genvar i = 0; i < CMP_W; i++) begin : g_bit
    assign bit_ok[i] = (use_mask_i && !msk_v[i]) || (cand[i] == ref_v[i]);
  end

  assign accept_o = &bit_ok;
endmodule

// File: rtl/msgobj_flags.sv
module msgobj_flags
  import msgobj_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  obj_ctl_t         wr_val_i,
  input  logic             dir_tx_i,
  input  logic             rx_store_i,
  input  logic [DLC_W-1:0] rx_dlc_i,
  input  logic             tx_done_i,
  output obj_ctl_t         ctl_o
);
  obj_ctl_t ctl_q, ctl_d;

  always_comb begin
    ctl_d = ctl_q;
    if (wr_en_i) begin
      ctl_d          = wr_val_i;
      ctl_d.msg_lost = wr_val_i.msg_lost && !dir_tx_i;
    end
    // handler events applied last so they win over a host write
    if (rx_store_i) begin
      ctl_d.new_dat = 1'b1;
      ctl_d.dlc     = rx_dlc_i;
      if (ctl_q.new_dat && !dir_tx_i) ctl_d.msg_lost = 1'b1;
      if (ctl_q.rx_ie)                ctl_d.int_pend = 1'b1;
    end
    if (tx_done_i && ctl_q.tx_ie) ctl_d.int_pend = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ctl_q <= '0;
    else         ctl_q <= ctl_d;
  end

  assign ctl_o = ctl_q;
endmodule

// File: rtl/msgobj_status.sv
module msgobj_status
  import msgobj_pkg::*;
#(
  parameter int unsigned ID_W = 29
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             host_wr_i,
  input  logic [REG_W-1:0] host_wdata_i,
  input  logic             busy_i,
  output logic [REG_W-1:0] host_rdata_o,
  input  logic             obj_dir_tx_i,
  input  logic             rx_store_i,
  input  logic [DLC_W-1:0] rx_dlc_i,
  input  logic             tx_done_i,
  input  logic [ID_W-1:0]  id_i,
  input  logic             id_xtd_i,
  input  logic             id_dir_i,
  input  logic [ID_W-1:0]  obj_id_i,
  input  logic             obj_xtd_i,
  input  logic             obj_dir_i,
  input  logic [ID_W-1:0]  msk_id_i,
  input  logic             msk_xtd_i,
  input  logic             msk_dir_i,
  output logic             accept_o,
  output logic             irq_o
);
  obj_ctl_t ctl;
  logic     wr_en;

  assign wr_en = host_wr_i && !busy_i;

  msgobj_flags u_flags (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en),
    .wr_val_i  (unpack_ctl(host_wdata_i)),
    .dir_tx_i  (obj_dir_tx_i),
    .rx_store_i(rx_store_i),
    .rx_dlc_i  (rx_dlc_i),
    .tx_done_i (tx_done_i),
    .ctl_o     (ctl)
  );

  msgobj_accept #(.ID_W(ID_W)) u_accept (
    .use_mask_i(ctl.use_mask),
    .id_i      (id_i),
    .id_xtd_i  (id_xtd_i),
    .id_dir_i  (id_dir_i),
    .obj_id_i  (obj_id_i),
    .obj_xtd_i (obj_xtd_i),
    .obj_dir_i (obj_dir_i),
    .msk_id_i  (msk_id_i),
    .msk_xtd_i (msk_xtd_i),
    .msk_dir_i (msk_dir_i),
    .accept_o  (accept_o)
  );

  assign host_rdata_o = pack_ctl(ctl);
  assign irq_o        = ctl.int_pend;
endmodule

// File: rtl/msgobj_status_chk.sv
module msgobj_status_chk
  import msgobj_pkg::*;
#(
  parameter int unsigned ID_W = 29
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             host_wr_i,
  input logic [REG_W-1:0] host_wdata_i,
  input logic             busy_i,
  input logic [REG_W-1:0] host_rdata_o,
  input logic             obj_dir_tx_i,
  input logic             rx_store_i,
  input logic             tx_done_i,
  input logic [ID_W-1:0]  id_i,
  input logic             id_xtd_i,
  input logic             id_dir_i,
  input logic [ID_W-1:0]  obj_id_i,
  input logic             obj_xtd_i,
  input logic             obj_dir_i,
  input logic             accept_o,
  input logic             irq_o
);
  logic hw;
  assign hw = host_wr_i && !busy_i;

  p_reserved_zero_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    host_rdata_o[REG_W-1:16] == '0 && host_rdata_o[6:4] == '0);

  p_lost_on_overwrite_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_store_i && host_rdata_o[B_NEW_DAT] && !obj_dir_tx_i && $stable(obj_dir_tx_i)
    |=> host_rdata_o[B_MSG_LOST]);

  p_tx_no_lost_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hw && obj_dir_tx_i |=> !host_rdata_o[B_MSG_LOST]);

  p_tx_irq_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_done_i && host_rdata_o[B_TX_IE] |=> host_rdata_o[B_INT_PEND]);

  p_tx_irq_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_done_i && !host_rdata_o[B_TX_IE] && !hw |=> $stable(host_rdata_o[B_INT_PEND]));

  p_newdat_set_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_store_i |=> host_rdata_o[B_NEW_DAT]);

  p_busy_block_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i && !rx_store_i && !tx_done_i |=> $stable(host_rdata_o));

  p_exact_match_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !host_rdata_o[B_USE_MASK] && accept_o
    |-> id_i == obj_id_i && id_xtd_i == obj_xtd_i && id_dir_i == obj_dir_i);

  p_rx_irq_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_store_i && host_rdata_o[B_RX_IE] |=> host_rdata_o[B_INT_PEND]);

  p_irq_mirror_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o == host_rdata_o[B_INT_PEND]);

  p_events_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rx_store_i && tx_done_i));

  p_wdata_unused: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hw && !rx_store_i && !tx_done_i |=> host_rdata_o[B_USE_MASK] == $past(host_wdata_i[B_USE_MASK]));
endmodule

bind msgobj_status msgobj_status_chk #(.ID_W(ID_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .host_wr_i   (host_wr_i),
  .host_wdata_i(host_wdata_i),
  .busy_i      (busy_i),
  .host_rdata_o(host_rdata_o),
  .obj_dir_tx_i(obj_dir_tx_i),
  .rx_store_i  (rx_store_i),
  .tx_done_i   (tx_done_i),
  .id_i        (id_i),
  .id_xtd_i    (id_xtd_i),
  .id_dir_i    (id_dir_i),
  .obj_id_i    (obj_id_i),
  .obj_xtd_i   (obj_xtd_i),
  .obj_dir_i   (obj_dir_i),
  .accept_o    (accept_o),
  .irq_o       (irq_o)
);

// File: tb/msgobj_status_test.sv
module msgobj_status_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_wr = 1'b0;
  logic [31:0] host_wdata = '0;
  logic        busy = 1'b0;
  logic [31:0] host_rdata;
  logic        dir_tx = 1'b0;
  logic        rx_store = 1'b0;
  logic [3:0]  rx_dlc = '0;
  logic        tx_done = 1'b0;
  logic [28:0] id = '0, obj_id = '0, msk_id = '0;
  logic        id_xtd = 1'b0, id_dir = 1'b0, obj_xtd = 1'b0, obj_dir = 1'b0;
  logic        msk_xtd = 1'b0, msk_dir = 1'b0;
  logic        accept, irq;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  // reference state
  bit m_nd, m_ml, m_ip, m_um, m_tie, m_rie, m_rm, m_tr, m_eob;
  bit [3:0] m_dlc;

  always #4ns clk = ~clk;

  msgobj_status uut (
    .clk_i(clk), .rst_ni(rst_n), .host_wr_i(host_wr), .host_wdata_i(host_wdata),
    .busy_i(busy), .host_rdata_o(host_rdata), .obj_dir_tx_i(dir_tx),
    .rx_store_i(rx_store), .rx_dlc_i(rx_dlc), .tx_done_i(tx_done),
    .id_i(id), .id_xtd_i(id_xtd), .id_dir_i(id_dir), .obj_id_i(obj_id),
    .obj_xtd_i(obj_xtd), .obj_dir_i(obj_dir), .msk_id_i(msk_id),
    .msk_xtd_i(msk_xtd), .msk_dir_i(msk_dir), .accept_o(accept), .irq_o(irq)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] model_word();
    logic [31:0] w = '0;
    w[15] = m_nd; w[14] = m_ml; w[13] = m_ip; w[12] = m_um; w[11] = m_tie;
    w[10] = m_rie; w[9] = m_rm; w[8] = m_tr; w[7] = m_eob; w[3:0] = m_dlc;
    return w;
  endfunction

  task automatic compare_all();
    logic [31:0] e = model_word();
    chk(host_rdata[15] == e[15], "R6 new-data", {31'd0, host_rdata[15]}, {31'd0, e[15]});
    chk(host_rdata[14] == e[14], "R3/R4 message-lost", {31'd0, host_rdata[14]}, {31'd0, e[14]});
    chk(host_rdata[13] == e[13], "R5/R10 interrupt-pending", {31'd0, host_rdata[13]}, {31'd0, e[13]});
    chk(host_rdata[3:0] == e[3:0], "R12 dlc", {28'd0, host_rdata[3:0]}, {28'd0, e[3:0]});
    chk(host_rdata[12:7] == e[12:7], "R7 control bits", {26'd0, host_rdata[12:7]}, {26'd0, e[12:7]});
    chk(host_rdata[31:16] == 0 && host_rdata[6:4] == 0, "R1 reserved zero", host_rdata, e);
    chk(irq == m_ip, "R11 irq mirror", {31'd0, irq}, {31'd0, m_ip});
  endtask

  // apply inputs at negedge, advance model to the post-edge state
  task automatic step();
    bit hw = host_wr && !busy;
    bit o_nd = m_nd, o_rie = m_rie, o_tie = m_tie;
    bit ref_acc = 1'b1;
    for (int i = 0; i < 29; i++)
      if (!(m_um && !msk_id[i]) && id[i] != obj_id[i]) ref_acc = 1'b0;
    if (!(m_um && !msk_xtd) && id_xtd != obj_xtd) ref_acc = 1'b0;
    if (!(m_um && !msk_dir) && id_dir != obj_dir) ref_acc = 1'b0;
    #1ns;
    chk(accept == ref_acc, m_um ? "R8 masked accept" : "R9 exact accept",
        {31'd0, accept}, {31'd0, ref_acc});
    if (hw) begin
      m_nd = host_wdata[15]; m_ml = host_wdata[14] && !dir_tx; m_ip = host_wdata[13];
      m_um = host_wdata[12]; m_tie = host_wdata[11]; m_rie = host_wdata[10];
      m_rm = host_wdata[9]; m_tr = host_wdata[8]; m_eob = host_wdata[7];
      m_dlc = host_wdata[3:0];
    end
    if (rx_store) begin
      m_nd = 1'b1; m_dlc = rx_dlc;
      if (o_nd && !dir_tx) m_ml = 1'b1;
      if (o_rie) m_ip = 1'b1;
    end
    if (tx_done && o_tie) m_ip = 1'b1;
    @(negedge clk);
    compare_all();
  endtask

  task automatic randomize_inputs(input int p_wr, input int p_busy, input int p_rx, input int p_tx);
    int ev = $urandom_range(99);
    host_wr    = ($urandom_range(99) < p_wr);
    host_wdata = $urandom();
    busy       = ($urandom_range(99) < p_busy);
    rx_store   = (ev < p_rx);
    tx_done    = (ev >= p_rx) && (ev < p_rx + p_tx);
    rx_dlc     = 4'($urandom());
    obj_id     = 29'($urandom());
    msk_id     = 29'($urandom());
    obj_xtd    = 1'($urandom()); obj_dir = 1'($urandom());
    msk_xtd    = 1'($urandom()); msk_dir = 1'($urandom());
    id         = obj_id ^ (($urandom_range(3) == 0) ? 29'd0 : (29'd1 << $urandom_range(28)));
    id_xtd     = obj_xtd ^ ($urandom_range(5) == 0);
    id_dir     = obj_dir ^ ($urandom_range(5) == 0);
  endtask

  task automatic idle();
    host_wr = 1'b0; busy = 1'b0; rx_store = 1'b0; tx_done = 1'b0;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    {m_nd, m_ml, m_ip, m_um, m_tie, m_rie, m_rm, m_tr, m_eob} = '0;
    m_dlc = '0;
    repeat (3) @(negedge clk);
    // R2: reset state, all zero
    chk(host_rdata == 32'd0, "R2 reset", host_rdata, 32'd0);
    chk(irq == 1'b0, "R2 reset irq", {31'd0, irq}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: write all ones, reserved bits stay zero
    host_wr = 1'b1; host_wdata = 32'hFFFF_FFFF;
    step();
    idle(); host_wdata = 32'h0000_0400;  // clear, keep rx irq enable
    host_wr = 1'b1;
    step();
    idle();
    // R3: two stores without host clear -> message lost
    rx_store = 1'b1; rx_dlc = 4'd8; step();
    rx_store = 1'b1; rx_dlc = 4'd3; step();
    idle();
    chk(host_rdata[14] == 1'b1, "R3 overwrite sets lost", {31'd0, host_rdata[14]}, 32'd1);
    chk(host_rdata[13] == 1'b1, "R10 rx irq", {31'd0, host_rdata[13]}, 32'd1);
    // R12: handler wins over a host clear of new-data
    host_wr = 1'b1; host_wdata = 32'h0; rx_store = 1'b1; rx_dlc = 4'd5; step();
    idle();
    chk(host_rdata[15] == 1'b1, "R12 handler wins", {31'd0, host_rdata[15]}, 32'd1);
    // R7: busy write ignored
    busy = 1'b1; host_wr = 1'b1; host_wdata = 32'h0; step();
    idle();
    chk(host_rdata[15] == 1'b1, "R7 busy write ignored", {31'd0, host_rdata[15]}, 32'd1);

    // receive-object phase
    dir_tx = 1'b0;
    for (int i = 0; i < 1500; i++) begin
      randomize_inputs(25, 30, 20, 10);
      step();
    end
    // transmit-object phase; flags held constant at boundary
    idle(); step();
    dir_tx = 1'b1;
    for (int i = 0; i < 1500; i++) begin
      randomize_inputs(25, 30, 10, 20);
      step();
    end
    // R5: tx with enable off leaves pending clear
    idle(); host_wr = 1'b1; host_wdata = 32'h0; step();
    idle(); tx_done = 1'b1; step();
    idle();
    chk(irq == 1'b0, "R5 tx no enable", {31'd0, irq}, 32'd0);
    host_wr = 1'b1; host_wdata = 32'h0000_0800; step();
    idle(); tx_done = 1'b1; step();
    idle();
    chk(irq == 1'b1, "R5 tx sets pending", {31'd0, irq}, 32'd1);
    // R4: host writes message-lost on tx object
    host_wr = 1'b1; host_wdata = 32'h0000_4000; step();
    idle();
    chk(host_rdata[14] == 1'b0, "R4 tx lost stays zero", {31'd0, host_rdata[14]}, 32'd0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule